// File: doc/BRIEF.md
# Inter-processor interrupt controller

This block lets any core in a four-core cluster post an interrupt request to one or more of its peers. Software writes to one of sixteen set addresses, one per cause, with a target-core mask in the write data. The addressed cause bit then becomes pending in every selected core. Each core owns a sixteen-bit pending-cause register. Reading it returns the pending causes. Writing ones to it acknowledges those causes, which clears them.

The sixteen causes fall into four groups of unequal size. A partition register holds one four-bit field per group, and each field names which of the four interrupt lines of a core that group drives. A field value above three detaches the group from all lines. This lets software decide which causes share a line and which get one to themselves. All accesses go through a single-cycle register port with registered read data.

Top module: `ipi_hub`

## Requirements
- R1: A synchronous active-high reset clears every pending cause, all interrupt lines and the read data. It loads the partition register with 0x3201, which routes group A to line 1, group B to line 0, group C to line 2 and group D to line 3.
- R2: A read of address 0x100+M, with M from 0 to 3, returns core M's pending causes in bits 15:0, with zeros above.
- R3: A write to address 0x140+n, with n from 0 to 15, makes cause n pending in every core c whose wdata bit c is 1. Other bits and other cores are left unchanged, and a zero mask changes nothing.
- R4: A write to address 0x100+M clears exactly those pending bits of core M that are 1 in wdata[15:0]. The write never sets a bit and does not touch other cores.
- R5: Group A is cause bit 0, group B is bits 3:1, group C is bits 7:4 and group D is bits 15:8. Group g's partition field is at bits 4g+3:4g. Core c's line k is output ipi_line[4c+k], and it is high when any pending bit of a group whose field equals k is set.
- R6: A group whose partition field holds a value from 4 to 15 drives no line.
- R7: Address 0x190 reads and writes the partition register. Only wdata[15:0] is stored, and a read returns it zero-extended.
- R8: Reads of set addresses or unmapped addresses return zero, and writes to unmapped addresses change no state.
- R9: rdata updates at the clock edge that samples rd_en and holds its value while rd_en is low. The interrupt lines follow a pending-state change one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Register address |
| wdata | input | 32 | Write data |
| wr_en | input | 1 | Write strobe, one access per cycle |
| rd_en | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| ipi_line | output | 16 | Interrupt lines, core c line k at bit 4c+k |

## Verification
The bench builds the block with its default parameters: four cores, sixteen causes, four lines per core and four-bit partition fields. These values put every group boundary (bits 0, 3, 4, 7, 8 and 15) and a field value of 0xF, which is beyond the line count, within reach. The bench also remaps groups so that two of them share one line, and it checks that a set address reads as zero. Reads are scored from a queue of expected values, and the interrupt lines are compared against a model built from the pending state and the partition fields.

// File: rtl/ipi_hub_pkg.sv
package ipi_hub_pkg;

  localparam int unsigned GROUPS       = 4;
  localparam int unsigned FIELD_W      = 4;
  localparam logic [15:0] PART_DEFAULT = 16'h3201;

  // Group index of a cause bit: 0 | 3:1 | 7:4 | 15:8
  function automatic int unsigned cause_group(input int unsigned bit_idx);
    if (bit_idx < 1)      return 0;
    else if (bit_idx < 4) return 1;
    else if (bit_idx < 8) return 2;
    else                  return 3;
  endfunction

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned CAUSE_BASE = 'h100,
  parameter int unsigned SET_BASE   = 'h140,
  parameter int unsigned PART_ADDR  = 'h190,
  localparam int unsigned IDX_W     = $clog2(NUM_CAUSES)
) (
  input  logic [ADDR_W-1:0]    addr,
  output logic [NUM_CORES-1:0] core_sel,
  output logic                 set_sel,
  output logic [IDX_W-1:0]     set_idx,
  output logic                 part_sel
);

  logic [ADDR_W-1:0] set_off;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign core_sel[c] = (addr == ADDR_W'(CAUSE_BASE + c));
  end

  assign set_off  = addr - ADDR_W'(SET_BASE);
  assign set_sel  = (addr >= ADDR_W'(SET_BASE)) && (set_off < ADDR_W'(NUM_CAUSES));
  assign set_idx  = set_off[IDX_W-1:0];
  assign part_sel = (addr == ADDR_W'(PART_ADDR));

endmodule

// File: rtl/ipi_cause_bank.sv
module ipi_cause_bank #(
  parameter int unsigned NUM_CAUSES = 16,
  localparam int unsigned IDX_W     = $clog2(NUM_CAUSES)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  set_en,
  input  logic [IDX_W-1:0]      set_idx,
  input  logic                  clr_en,
  input  logic [NUM_CAUSES-1:0] clr_mask,
  output logic [NUM_CAUSES-1:0] pend
);

  logic [NUM_CAUSES-1:0] pend_nxt;

  always_comb begin
    pend_nxt = pend;
    if (clr_en) pend_nxt = pend_nxt & ~clr_mask;
    if (set_en) pend_nxt[set_idx] = 1'b1;   // set applied last, so it wins
  end

  always_ff @(posedge clk) begin
    if (rst) pend <= '0;
    else     pend <= pend_nxt;
  end

endmodule

// File: rtl/ipi_line_router.sv
module ipi_line_router
  import ipi_hub_pkg::*;
#(
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned NUM_LINES  = 4,
  localparam int unsigned PART_W    = GROUPS * FIELD_W
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NUM_CAUSES-1:0] pend,
  input  logic [PART_W-1:0]     part,
  output logic [NUM_LINES-1:0]  line
);

  logic [GROUPS-1:0][NUM_CAUSES-1:0] gmask;
  logic [GROUPS-1:0]                 grp_hit;
  logic [NUM_LINES-1:0]              line_nxt;

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < NUM_CAUSES; b++) begin : g_bit
      assign gmask[g][b] = (cause_group(b) == g);
    end
    assign grp_hit[g] = |(pend & gmask[g]);
  end

  always_comb begin
    line_nxt = '0;
    for (int k = 0; k < NUM_LINES; k++) begin
      for (int g = 0; g < GROUPS; g++) begin
        if (grp_hit[g] && (part[g*FIELD_W +: FIELD_W] == FIELD_W'(k)))
          line_nxt[k] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) line <= '0;
    else     line <= line_nxt;
  end

endmodule

// File: rtl/ipi_hub.sv
module ipi_hub
  import ipi_hub_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned CAUSE_BASE = 'h100,
  parameter int unsigned SET_BASE   = 'h140,
  parameter int unsigned PART_ADDR  = 'h190,
  localparam int unsigned IDX_W     = $clog2(NUM_CAUSES),
  localparam int unsigned PART_W    = GROUPS * FIELD_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  input  logic                           wr_en,
  input  logic                           rd_en,
  output logic [DATA_W-1:0]              rdata,
  output logic [NUM_CORES*NUM_LINES-1:0] ipi_line
);

  logic [NUM_CORES-1:0]            core_sel;
  logic                            set_sel;
  logic [IDX_W-1:0]                set_idx;
  logic                            part_sel;
  logic [PART_W-1:0]               part_q;
  logic [NUM_CAUSES-1:0]           pend [NUM_CORES];
  logic [NUM_CORES*NUM_CAUSES-1:0] pend_flat;
  logic [DATA_W-1:0]               rd_mux;
  logic                            unused_wdata;

  assign unused_wdata = ^wdata;

  ipi_addr_decode #(
    .ADDR_W(ADDR_W), .NUM_CORES(NUM_CORES), .NUM_CAUSES(NUM_CAUSES),
    .CAUSE_BASE(CAUSE_BASE), .SET_BASE(SET_BASE), .PART_ADDR(PART_ADDR)
  ) u_dec (
    .addr(addr), .core_sel(core_sel), .set_sel(set_sel),
    .set_idx(set_idx), .part_sel(part_sel)
  );

  always_ff @(posedge clk) begin
    if (rst)                     part_q <= PART_DEFAULT;
    else if (wr_en && part_sel)  part_q <= wdata[PART_W-1:0];
  end

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    ipi_cause_bank #(.NUM_CAUSES(NUM_CAUSES)) u_bank (
      .clk(clk), .rst(rst),
      .set_en(wr_en && set_sel && wdata[c]),
      .set_idx(set_idx),
      .clr_en(wr_en && core_sel[c]),
      .clr_mask(wdata[NUM_CAUSES-1:0]),
      .pend(pend[c])
    );

    assign pend_flat[c*NUM_CAUSES +: NUM_CAUSES] = pend[c];

    ipi_line_router #(.NUM_CAUSES(NUM_CAUSES), .NUM_LINES(NUM_LINES)) u_route (
      .clk(clk), .rst(rst), .pend(pend[c]), .part(part_q),
      .line(ipi_line[c*NUM_LINES +: NUM_LINES])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int c = 0; c < NUM_CORES; c++)
      if (core_sel[c]) rd_mux = rd_mux | DATA_W'(pend[c]);
    if (part_sel) rd_mux = rd_mux | DATA_W'(part_q);
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/ipi_hub_chk.sv
module ipi_hub_chk #(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned DATA_W     = 32,
  parameter int unsigned NUM_CORES  = 4,
  parameter int unsigned NUM_CAUSES = 16,
  parameter int unsigned NUM_LINES  = 4,
  parameter int unsigned CAUSE_BASE = 'h100,
  parameter int unsigned SET_BASE   = 'h140,
  parameter int unsigned PART_ADDR  = 'h190
) (
  input logic                            clk,
  input logic                            rst,
  input logic [ADDR_W-1:0]               addr,
  input logic [DATA_W-1:0]               wdata,
  input logic                            wr_en,
  input logic                            rd_en,
  input logic [DATA_W-1:0]               rdata,
  input logic [NUM_CORES*NUM_LINES-1:0]  ipi_line,
  input logic [NUM_CORES*NUM_CAUSES-1:0] pend_flat
);

  logic a_set, a_cause, a_mapped;
  assign a_set    = (addr >= ADDR_W'(SET_BASE)) && (addr < ADDR_W'(SET_BASE + NUM_CAUSES));
  assign a_cause  = (addr >= ADDR_W'(CAUSE_BASE)) && (addr < ADDR_W'(CAUSE_BASE + NUM_CORES));
  assign a_mapped = a_set || a_cause || (addr == ADDR_W'(PART_ADDR));

  AST_RST_CLEARS: assert property (@(posedge clk) rst |=> (ipi_line == '0 && rdata == '0 && pend_flat == '0)); // R1
  AST_SET_READS_ZERO: assert property (@(posedge clk) disable iff (rst) (rd_en && a_set) |=> (rdata == '0)); // R8
  AST_UNMAPPED_WR_INERT: assert property (@(posedge clk) disable iff (rst) (wr_en && !a_mapped) |=> $stable(pend_flat)); // R8
  AST_CLEAR_NEVER_SETS: assert property (@(posedge clk) disable iff (rst) (wr_en && a_cause) |=> ((pend_flat & ~$past(pend_flat)) == '0)); // R4
  AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst) (wr_en && a_set && wdata[NUM_CORES-1:0] != '0) |=> (pend_flat != '0)); // R3
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst) !rd_en |=> $stable(rdata)); // R9
  AST_IDLE_LINES_LOW: assert property (@(posedge clk) disable iff (rst) ($past(pend_flat) == '0) |-> (ipi_line == '0)); // R5

endmodule

bind ipi_hub ipi_hub_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_CORES(NUM_CORES), .NUM_CAUSES(NUM_CAUSES),
  .NUM_LINES(NUM_LINES), .CAUSE_BASE(CAUSE_BASE), .SET_BASE(SET_BASE), .PART_ADDR(PART_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
  .rdata(rdata), .ipi_line(ipi_line), .pend_flat(pend_flat)
);

// File: tb/ipi_hub_tb.sv
`timescale 1ns/1ps
module ipi_hub_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [31:0] rdata;
  logic [15:0] ipi_line;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [15:0] exp_pend [4];
  logic [15:0] exp_part;

  logic [31:0] exp_q [$];
  string       tag_q [$];
  logic        rd_fire;

  always #4 clk = ~clk;   // 125 MHz

  ipi_hub u_dut (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .ipi_line(ipi_line)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Monitor: a read sampled at a posedge is scored at the following negedge
  always @(posedge clk) rd_fire <= rst ? 1'b0 : rd_en;

  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) check("scoreboard-empty", rdata, 32'hx);
      else check(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  function automatic logic [3:0] model_lines(input int c);
    logic [3:0] r = '0;
    for (int b = 0; b < 16; b++) begin
      int grp = (b == 0) ? 0 : (b <= 3) ? 1 : (b <= 7) ? 2 : 3;
      logic [3:0] f = exp_part[grp*4 +: 4];
      if (exp_pend[c][b] && f < 4) r[f[1:0]] = 1'b1;
    end
    return r;
  endfunction

  task automatic do_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic set_cause(input int n, input logic [3:0] mask);
    do_write(12'h140 + 12'(n), {28'h0, mask});
    for (int c = 0; c < 4; c++) if (mask[c]) exp_pend[c][n] = 1'b1;
  endtask

  task automatic clear_cause(input int c, input logic [15:0] m);
    do_write(12'h100 + 12'(c), {16'hFFFF, m});
    exp_pend[c] = exp_pend[c] & ~m;
  endtask

  task automatic check_lines(input string req);
    @(negedge clk);   // lines lag the pending state by one clock
    for (int c = 0; c < 4; c++) check(req, {28'h0, ipi_line[c*4 +: 4]}, {28'h0, model_lines(c)});
  endtask

  task automatic read_all_causes(input string tag);
    for (int c = 0; c < 4; c++) do_read(12'h100 + 12'(c), {16'h0, exp_pend[c]}, tag);
  endtask

  initial begin
    for (int c = 0; c < 4; c++) exp_pend[c] = '0;
    exp_part = 16'h3201;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 lines", {16'h0, ipi_line}, 32'h0);
    check("R1 rdata", rdata, 32'h0);
    do_read(12'h190, 32'h3201, "R1 partition default");
    read_all_causes("R1 causes clear");

    // R3/R5: cause 4 (group C) to cores 0 and 2 -> line 2
    set_cause(4, 4'b0101);
    check_lines("R5 group C on line 2");
    read_all_causes("R2 R3 cause 4");

    // R5: cause 0 (group A) to core 1 -> line 1
    set_cause(0, 4'b0010);
    check_lines("R5 group A on line 1");
    // cause 9 (group D) to all, cause 3 (group B) to core 3
    set_cause(9, 4'b1111);
    set_cause(3, 4'b1000);
    set_cause(15, 4'b0001);
    set_cause(8, 4'b0000);   // R3 zero mask: nothing
    check_lines("R5 groups B D");
    read_all_causes("R3 accumulate and zero mask");

    // R4 clear core 0 bit 4 only
    clear_cause(0, 16'h0010);
    check_lines("R4 clear lines");
    read_all_causes("R4 selective clear");

    // R6/R7: group C -> none, group D -> line 0, group B -> line 0, A -> line 1
    do_write(12'h190, 32'hABCD_0F01);
    exp_part = 16'h0F01;
    check_lines("R6 field F detaches");
    do_read(12'h190, 32'h0000_0F01, "R7 partition readback");

    // R9: rdata holds with rd_en low
    repeat (3) @(negedge clk);
    check("R9 rdata hold", rdata, 32'h0000_0F01);

    // R8: set addresses read zero, unmapped reads zero, unmapped writes inert
    do_read(12'h145, 32'h0, "R8 set address read");
    do_read(12'h0FF, 32'h0, "R8 unmapped read");
    do_write(12'h104, 32'hFFFF_FFFF);
    do_write(12'h1A0, 32'hFFFF_FFFF);
    do_write(12'h150, 32'h0000_000F);
    check_lines("R8 unmapped write lines");
    read_all_causes("R8 unmapped write state");
    do_read(12'h190, 32'h0000_0F01, "R8 partition untouched");

    // R5 restore default routing
    do_write(12'h190, 32'h0000_3201);
    exp_part = 16'h3201;
    check_lines("R5 default routing again");

    // R4: acknowledge everything
    for (int c = 0; c < 4; c++) clear_cause(c, 16'hFFFF);
    check_lines("R4 all cleared");
    read_all_causes("R4 all cleared read");

    repeat (2) @(negedge clk);
    check("R1 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule